// File: doc/BRIEF.md
# Interrupt Call Sequencer

This block sits next to a small in-order CPU and converts a pending, enabled interrupt into a call that the hardware generates itself. Several module request lines are gated by a per-module mask and merged into one pending line. The merged line is registered on the rising clock edge. An eligible request is then acknowledged, and one stall cycle lets the instruction in flight, which may itself use the stack, run to completion. The sequencer then drops the next program fetch and hands the return address to the stack through a request/acknowledge handshake. It sets the in-service flag and loads the instruction pointer with the vector address.

The same block runs the return-from-interrupt sequence. It requests a pop from the stack, clears the in-service flag when the pop completes, and loads the instruction pointer with the popped address. A return can never be interrupted. The current instruction can raise a no-interrupt window, which holds back acknowledgement for that cycle so that an instruction pair runs without a break. Software can clear the in-service flag early to allow nested service.

Top module: `irq_call_seq`

## Requirements
- R1: A request that reaches the merged line in cycle c appears in the sampled register in cycle c+1. If it is eligible there, it is acknowledged in cycle c+1, stalls in cycle c+2, and fetch_cancel is high in cycle c+3. fetch_cancel is never high without an acknowledged stall cycle in the cycle before it.
- R2: An acknowledged request waits in the stall state until inst_done is high. fetch_cancel follows one cycle after the stall cycle in which inst_done is high, and seq_busy stays 0 while it waits.
- R3: The service order is fixed:
  - fetch_cancel is high for one cycle.
  - push_req is then high, with push_data holding ret_addr as it was in the stall cycle that started service, until push_ack is seen.
  - In the cycle after the acknowledge, in_service reads 1 and ip_load is high for one cycle with ip_value equal to vec_addr as it was at the acknowledge.
- R4: When reti_exec is high while the sequencer is idle, pop_req goes high in the next cycle and stays high until pop_ack. In the cycle after pop_ack, in_service reads 0 and ip_load is high with ip_value equal to the pop_data that came with the acknowledge.
- R5: No request is acknowledged during a return sequence or in the cycle that reti_exec is high. The earliest acknowledgement is in the first idle cycle after the return ip_load, so fetch_cancel comes 3 cycles after the return ip_load at the earliest.
- R6: A request is not acknowledged in a cycle where no_irq_win is high. When the window lasts one cycle, service comes one cycle later than under R1.
- R7: A request is acknowledged only when glb_en is 1 and in_service is 0. When glb_en rises with a request already sampled, fetch_cancel follows 2 cycles later.
- R8: ins_clear high for one cycle makes in_service read 0 in the next cycle. A sampled request can then be acknowledged in that cycle, which gives fetch_cancel 3 cycles after the ins_clear cycle.
- R9: A source whose bit in src_mask is 0 never causes service. Bit i of src_mask gates bit i of src_req.
- R10: After reset, fetch_cancel, push_req, pop_req, ip_load, in_service and seq_busy are all 0.
- R11: seq_busy is 1 from the fetch_cancel cycle through the ip_load cycle of either sequence, and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Per-module interrupt request lines |
| src_mask | input | N_SRC | Per-module enable mask, 1 lets the source through |
| glb_en | input | 1 | Global interrupt enable |
| inst_done | input | 1 | The current instruction completes in this cycle |
| no_irq_win | input | 1 | The current instruction forbids acknowledgement this cycle |
| reti_exec | input | 1 | A return-from-interrupt instruction is executing |
| ins_clear | input | 1 | Software clear of the in-service flag |
| ret_addr | input | AW | Return address to save on the stack |
| vec_addr | input | AW | Interrupt vector address |
| fetch_cancel | output | 1 | Drop the next program fetch |
| push_req | output | 1 | Stack push request |
| push_data | output | AW | Return address carried by the push |
| push_ack | input | 1 | Stack push completed |
| pop_req | output | 1 | Stack pop request |
| pop_ack | input | 1 | Stack pop completed, pop_data valid |
| pop_data | input | AW | Address returned by the pop |
| ip_load | output | 1 | Load the instruction pointer this cycle |
| ip_value | output | AW | New instruction pointer value |
| in_service | output | 1 | Interrupt in service flag |
| seq_busy | output | 1 | Sequencer owns the CPU; hold the pipeline |

## Verification
A stuck or spurious acknowledge register shows up at the ports within three cycles. It appears as a fetch_cancel with no request, or as a missing one, and the scoreboard catches it by the exact cycle of each strobe. A wrong in-service flag is visible right away on in_service. One cycle later it shows as a nested call that should have been blocked, or as an interrupt after a return that never arrives. A return address or vector held in the wrong register shows in the value that comes with the push or the ip_load strobe. The bench compares these values for every sequence, including ones with delayed stack acknowledges.

// File: rtl/isq_pkg.sv
package isq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_CANCEL  = 3'd1,
      SQ_PUSH    = 3'd2,
      SQ_VECTOR  = 3'd3,
      SQ_POP     = 3'd4,
      SQ_RESTORE = 3'd5
   } sq_state_t;

endpackage

// File: rtl/isq_req_sample.sv
module isq_req_sample #(
   parameter int N_SRC        = 4,
   parameter bit PER_SRC_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_mask,
   output logic             req_q
);

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("isq_req_sample: N_SRC must be at least 1");
   end

   logic [N_SRC-1:0] gated;

   for (genvar i = 0; i < N_SRC; i++) begin : g_gate
      assign gated[i] = src_req[i] & src_mask[i];
   end

   if (PER_SRC_FLOP) begin : g_flop_each
      logic [N_SRC-1:0] hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= '0;
         else        hit_q <= gated;
      end
      assign req_q = |hit_q;
   end else begin : g_flop_merged
      logic any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) any_q <= 1'b0;
         else        any_q <= |gated;
      end
      assign req_q = any_q;
   end

   // R9: masked-off or idle sources never reach the sampled line
   p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_req & src_mask) == '0) |=> !req_q);

endmodule

// File: rtl/isq_arm.sv
module isq_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic req_q,
   input  logic glb_en,
   input  logic in_service,
   input  logic no_irq_win,
   input  logic reti_exec,
   input  logic inst_done,
   input  logic idle,
   output logic armed_q,
   output logic take
);

   logic eligible;
   logic armed_d;

   assign eligible = req_q & glb_en & ~in_service & ~no_irq_win;

   always_comb begin
      armed_d = 1'b0;
      if (idle && !reti_exec) begin
         if (armed_q) armed_d = ~inst_done;
         else         armed_d = eligible;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end

   assign take = armed_q & inst_done & idle & ~reti_exec;

   // R5: a return instruction cancels any acknowledgement
   p_reti_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reti_exec |=> !armed_q);

   // R6: no acknowledgement inside a no-interrupt window
   p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && no_irq_win) |=> !armed_q);

   // R7: enable and in-service gate the acknowledgement
   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && (!glb_en || in_service)) |=> !armed_q);

   // R2: an acknowledged request waits while the instruction is unfinished
   p_wait_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && idle && !inst_done && !reti_exec) |=> armed_q);

endmodule

// File: rtl/isq_fsm.sv
module isq_fsm
   import isq_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          reti_exec,
   input  logic          ins_clear,
   input  logic [AW-1:0] ret_addr,
   input  logic [AW-1:0] vec_addr,
   input  logic          push_ack,
   input  logic          pop_ack,
   input  logic [AW-1:0] pop_data,
   output logic          idle,
   output logic          fetch_cancel,
   output logic          push_req,
   output logic [AW-1:0] push_data,
   output logic          pop_req,
   output logic          ip_load,
   output logic [AW-1:0] ip_value,
   output logic          in_service,
   output logic          seq_busy
);

   if (AW < 2) begin : g_bad_aw
      $error("isq_fsm: AW must be at least 2");
   end

   sq_state_t     st_q, st_d;
   logic          ins_q;
   logic [AW-1:0] ret_q;
   logic [AW-1:0] ip_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: begin
            if (reti_exec) st_d = SQ_POP;
            else if (take) st_d = SQ_CANCEL;
         end
         SQ_CANCEL:  st_d = SQ_PUSH;
         SQ_PUSH:    if (push_ack) st_d = SQ_VECTOR;
         SQ_VECTOR:  st_d = SQ_IDLE;
         SQ_POP:     if (pop_ack) st_d = SQ_RESTORE;
         SQ_RESTORE: st_d = SQ_IDLE;
         default:    st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         ins_q <= 1'b0;
         ret_q <= '0;
         ip_q  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == SQ_IDLE && !reti_exec && take)
            ret_q <= ret_addr;
         if (st_q == SQ_PUSH && push_ack) begin
            ins_q <= 1'b1;
            ip_q  <= vec_addr;
         end else if (st_q == SQ_POP && pop_ack) begin
            ins_q <= 1'b0;
            ip_q  <= pop_data;
         end else if (ins_clear) begin
            ins_q <= 1'b0;
         end
      end
   end

   assign idle         = (st_q == SQ_IDLE);
   assign fetch_cancel = (st_q == SQ_CANCEL);
   assign push_req     = (st_q == SQ_PUSH);
   assign push_data    = ret_q;
   assign pop_req      = (st_q == SQ_POP);
   assign ip_load      = (st_q == SQ_VECTOR) || (st_q == SQ_RESTORE);
   assign ip_value     = ip_q;
   assign in_service   = ins_q;
   assign seq_busy     = ~idle;

   // R3: cancel is followed directly by the push request
   p_cancel_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_cancel |=> push_req);

   // R3: an unanswered push keeps its request and its address
   p_push_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !push_ack) |=> (push_req && $stable(push_data)));

   // R3: completed push sets in-service and loads the vector
   p_push_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && push_ack) |=> (in_service && ip_load && ip_value == $past(vec_addr)));

   // R4: completed pop clears in-service and restores the address
   p_pop_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && pop_ack) |=> (!in_service && ip_load && ip_value == $past(pop_data)));

   // R3: at most one sequencing strobe per cycle
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_cancel, push_req, pop_req, ip_load}));

endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq #(
   parameter int N_SRC        = 4,
   parameter int AW           = 16,
   parameter bit PER_SRC_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] src_mask,
   input  logic             glb_en,
   input  logic             inst_done,
   input  logic             no_irq_win,
   input  logic             reti_exec,
   input  logic             ins_clear,
   input  logic [AW-1:0]    ret_addr,
   input  logic [AW-1:0]    vec_addr,
   output logic             fetch_cancel,
   output logic             push_req,
   output logic [AW-1:0]    push_data,
   input  logic             push_ack,
   output logic             pop_req,
   input  logic             pop_ack,
   input  logic [AW-1:0]    pop_data,
   output logic             ip_load,
   output logic [AW-1:0]    ip_value,
   output logic             in_service,
   output logic             seq_busy
);

   logic req_q;
   logic armed_q;
   logic take;
   logic idle;

   isq_req_sample #(
      .N_SRC        (N_SRC),
      .PER_SRC_FLOP (PER_SRC_FLOP)
   ) u_sample (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_req  (src_req),
      .src_mask (src_mask),
      .req_q    (req_q)
   );

   isq_arm u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_q      (req_q),
      .glb_en     (glb_en),
      .in_service (in_service),
      .no_irq_win (no_irq_win),
      .reti_exec  (reti_exec),
      .inst_done  (inst_done),
      .idle       (idle),
      .armed_q    (armed_q),
      .take       (take)
   );

   isq_fsm #(.AW(AW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .reti_exec    (reti_exec),
      .ins_clear    (ins_clear),
      .ret_addr     (ret_addr),
      .vec_addr     (vec_addr),
      .push_ack     (push_ack),
      .pop_ack      (pop_ack),
      .pop_data     (pop_data),
      .idle         (idle),
      .fetch_cancel (fetch_cancel),
      .push_req     (push_req),
      .push_data    (push_data),
      .pop_req      (pop_req),
      .ip_load      (ip_load),
      .ip_value     (ip_value),
      .in_service   (in_service),
      .seq_busy     (seq_busy)
   );

   // R1: fetch cancel only after a stall cycle with an acknowledged request
   p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_cancel |-> ($past(armed_q) && !$past(fetch_cancel)));

   // R11: busy covers every strobe of both sequences
   p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_cancel || push_req || pop_req || ip_load) |-> seq_busy);

endmodule

// File: tb/sim_irq_call_seq.sv
`timescale 1ns/1ps
module sim_irq_call_seq;

   localparam int NS = 4;
   localparam int AW = 16;
   localparam int EV_CANCEL = 0;
   localparam int EV_PUSH   = 1;
   localparam int EV_LOAD   = 2;
   localparam logic [AW-1:0] VEC = 16'h0A00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic [NS-1:0] src_mask = '1;
   logic          glb_en = 1'b1;
   logic          inst_done = 1'b1;
   logic          no_irq_win = 1'b0;
   logic          reti_exec = 1'b0;
   logic          ins_clear = 1'b0;
   logic [AW-1:0] ret_addr = '0;
   logic [AW-1:0] vec_addr = VEC;
   logic          fetch_cancel, push_req, pop_req, ip_load, in_service, seq_busy;
   logic [AW-1:0] push_data, ip_value;
   logic          push_ack = 1'b0;
   logic          pop_ack = 1'b0;
   logic [AW-1:0] pop_data = '0;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int push_dly = 0;
   int pop_dly = 0;
   int pw = 0;
   int pr = 0;
   logic [AW-1:0] pop_val = '0;
   string cur_tag = "R10";

   int            qk[$];
   int            qc[$];
   logic [AW-1:0] qv[$];
   string         qt[$];

   irq_call_seq #(.N_SRC(NS), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
      .glb_en(glb_en), .inst_done(inst_done), .no_irq_win(no_irq_win),
      .reti_exec(reti_exec), .ins_clear(ins_clear), .ret_addr(ret_addr),
      .vec_addr(vec_addr), .fetch_cancel(fetch_cancel), .push_req(push_req),
      .push_data(push_data), .push_ack(push_ack), .pop_req(pop_req),
      .pop_ack(pop_ack), .pop_data(pop_data), .ip_load(ip_load),
      .ip_value(ip_value), .in_service(in_service), .seq_busy(seq_busy)
   );

   always #10 clk = ~clk;

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         summary();
         $finish;
      end
   end

   // stack model: answers requests after a programmable number of cycles
   always @(negedge clk) begin
      if (push_req) begin
         push_ack <= (pw >= push_dly);
         pw = pw + 1;
      end else begin
         push_ack <= 1'b0;
         pw = 0;
      end
      if (pop_req) begin
         pop_ack  <= (pr >= pop_dly);
         pop_data <= pop_val;
         pr = pr + 1;
      end else begin
         pop_ack <= 1'b0;
         pr = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exv);
      end
   endtask

   task automatic expect_ev(input int kind, input int at, input logic [AW-1:0] v,
                            input string tag);
      qk.push_back(kind);
      qc.push_back(at);
      qv.push_back(v);
      qt.push_back(tag);
   endtask

   task automatic see_ev(input int kind, input logic [AW-1:0] v);
      if (qk.size() == 0) begin
         chk(1'b0, cur_tag, "unexpected event kind", kind, -1);
      end else begin
         int k, c;
         logic [AW-1:0] ev;
         string t;
         k = qk.pop_front(); c = qc.pop_front();
         ev = qv.pop_front(); t = qt.pop_front();
         chk(k == kind, t, "event kind", kind, k);
         chk(c == cyc, t, "event cycle", cyc, c);
         chk(ev == v, t, "event value", int'(v), int'(ev));
      end
   endtask

   // monitor: sample after the drivers have settled
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (fetch_cancel)         see_ev(EV_CANCEL, '0);
         if (push_req && push_ack) see_ev(EV_PUSH, push_data);
         if (ip_load)              see_ev(EV_LOAD, ip_value);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reti(input logic [AW-1:0] pv, input int d, input string tag);
      int r;
      r = cyc;
      pop_val = pv;
      pop_dly = d;
      reti_exec = 1'b1;
      expect_ev(EV_LOAD, r + 2 + d, pv, tag);
      step(1);
      reti_exec = 1'b0;
      step(3 + d);
   endtask

   initial begin
      int n;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R10: reset state
      chk({fetch_cancel, push_req, pop_req, ip_load, in_service, seq_busy} == 6'b0,
          "R10", "outputs after reset",
          int'({fetch_cancel, push_req, pop_req, ip_load, in_service, seq_busy}), 0);

      // R1 / R3 / R11: basic service
      cur_tag = "R1";
      n = cyc;
      ret_addr = 16'h1230;
      src_req = 4'b0100;
      expect_ev(EV_CANCEL, n + 3, '0, "R1");
      expect_ev(EV_PUSH, n + 4, 16'h1230, "R3");
      expect_ev(EV_LOAD, n + 5, VEC, "R3");
      step(4);
      chk(seq_busy == 1'b1, "R11", "busy during push", seq_busy, 1);
      step(2);
      chk(in_service == 1'b1, "R3", "in_service after entry", in_service, 1);
      chk(seq_busy == 1'b0, "R11", "busy after entry", seq_busy, 0);

      // R7: no nesting while in service
      cur_tag = "R7";
      step(8);

      // R4 / R5: return with a request still pending
      cur_tag = "R5";
      n = cyc;
      ret_addr = 16'h2460;
      pop_val = 16'h0111;
      pop_dly = 0;
      reti_exec = 1'b1;
      expect_ev(EV_LOAD, n + 2, 16'h0111, "R4");
      expect_ev(EV_CANCEL, n + 5, '0, "R5");
      expect_ev(EV_PUSH, n + 6, 16'h2460, "R5");
      expect_ev(EV_LOAD, n + 7, VEC, "R5");
      step(1);
      reti_exec = 1'b0;
      step(1);
      chk(in_service == 1'b0, "R4", "in_service on restore", in_service, 0);
      step(6);
      chk(in_service == 1'b1, "R5", "in_service after re-entry", in_service, 1);
      src_req = '0;
      do_reti(16'h0222, 0, "R4");

      // R6: one-cycle no-interrupt window
      cur_tag = "R6";
      n = cyc;
      src_req = 4'b0001;
      expect_ev(EV_CANCEL, n + 4, '0, "R6");
      expect_ev(EV_PUSH, n + 5, 16'h2460, "R6");
      expect_ev(EV_LOAD, n + 6, VEC, "R6");
      step(1);
      no_irq_win = 1'b1;
      step(1);
      no_irq_win = 1'b0;
      step(5);
      src_req = '0;
      do_reti(16'h0333, 0, "R4");

      // R7: global enable gates acknowledgement
      cur_tag = "R7";
      glb_en = 1'b0;
      src_req = 4'b1000;
      step(8);
      chk(seq_busy == 1'b0, "R7", "busy with enable off", seq_busy, 0);
      n = cyc;
      glb_en = 1'b1;
      ret_addr = 16'h3690;
      expect_ev(EV_CANCEL, n + 2, '0, "R7");
      expect_ev(EV_PUSH, n + 3, 16'h3690, "R7");
      expect_ev(EV_LOAD, n + 4, VEC, "R7");
      step(5);
      src_req = '0;
      do_reti(16'h0444, 0, "R4");

      // R9: masked source ignored, unmasked source served
      cur_tag = "R9";
      src_mask = 4'b1101;
      src_req = 4'b0010;
      step(8);
      chk(in_service == 1'b0, "R9", "in_service with masked source", in_service, 0);
      n = cyc;
      src_req = 4'b0011;
      expect_ev(EV_CANCEL, n + 3, '0, "R9");
      expect_ev(EV_PUSH, n + 4, 16'h3690, "R9");
      expect_ev(EV_LOAD, n + 5, VEC, "R9");
      step(6);
      src_req = '0;
      src_mask = '1;
      do_reti(16'h0555, 0, "R4");

      // R2: stall holds until the instruction completes
      cur_tag = "R2";
      n = cyc;
      inst_done = 1'b0;
      src_req = 4'b0001;
      expect_ev(EV_CANCEL, n + 6, '0, "R2");
      expect_ev(EV_PUSH, n + 7, 16'h3690, "R2");
      expect_ev(EV_LOAD, n + 8, VEC, "R2");
      step(4);
      chk(seq_busy == 1'b0, "R2", "busy while waiting", seq_busy, 0);
      step(1);
      inst_done = 1'b1;
      step(4);
      src_req = '0;
      do_reti(16'h0666, 0, "R4");

      // R8: software clear of in-service allows nesting
      cur_tag = "R8";
      n = cyc;
      ret_addr = 16'h4000;
      src_req = 4'b0100;
      expect_ev(EV_CANCEL, n + 3, '0, "R8");
      expect_ev(EV_PUSH, n + 4, 16'h4000, "R8");
      expect_ev(EV_LOAD, n + 5, VEC, "R8");
      step(7);
      n = cyc;
      ins_clear = 1'b1;
      ret_addr = 16'h4444;
      expect_ev(EV_CANCEL, n + 3, '0, "R8");
      expect_ev(EV_PUSH, n + 4, 16'h4444, "R8");
      expect_ev(EV_LOAD, n + 5, VEC, "R8");
      step(1);
      ins_clear = 1'b0;
      chk(in_service == 1'b0, "R8", "in_service after clear", in_service, 0);
      step(5);
      chk(in_service == 1'b1, "R8", "in_service after nested entry", in_service, 1);
      src_req = '0;
      do_reti(16'h0777, 0, "R4");
      do_reti(16'h0888, 0, "R4");

      // R3: delayed push acknowledge, R4: delayed pop acknowledge
      cur_tag = "R3";
      push_dly = 2;
      n = cyc;
      ret_addr = 16'h5A5A;
      src_req = 4'b0010;
      expect_ev(EV_CANCEL, n + 3, '0, "R3");
      expect_ev(EV_PUSH, n + 6, 16'h5A5A, "R3");
      expect_ev(EV_LOAD, n + 7, VEC, "R3");
      step(5);
      chk(push_req == 1'b1, "R3", "push held while unanswered", push_req, 1);
      step(3);
      src_req = '0;
      push_dly = 0;
      do_reti(16'h0999, 2, "R4");
      chk(in_service == 1'b0, "R4", "in_service after delayed pop", in_service, 0);

      step(4);
      while (qk.size() > 0) begin
         chk(1'b0, qt[0], "missing event at cycle", -1, qc[0]);
         void'(qk.pop_front()); void'(qc.pop_front());
         void'(qv.pop_front()); void'(qt.pop_front());
      end
      summary();
      $finish;
   end

endmodule